// File: doc/BRIEF.md
# Isochronous OUT Endpoint Receive Buffer

This block buffers the data of one isochronous OUT endpoint of a full-speed USB device. The serial engine delivers each packet as a stream of bytes. Each byte comes with a valid strobe, and an end-of-packet strobe marks the last byte. The CPU takes the bytes out through a pop port, one byte at a time, and reads a 32-bit control/status word. It clears the sticky event flags in that word by writing 1 to them.

The buffer counts whole packets as well as bytes. A packet is made visible to the CPU only when its last byte arrives, and packets leave the buffer in arrival order. Isochronous traffic cannot be retried, so the buffer never holds the host off. If a byte arrives while the storage is full, the partly stored packet is removed and the rest of that packet is thrown away. The sticky overflow flag records the loss.

Top module: `iso_out_rxbuf`

## Requirements
- R1: After reset, csr_rdata reads 0x00000000 and cpu_rdata reads 0.
- R2: The status word has these bits: bit 0 service, bit 1 packet-done, bit 2 overflow, bit 6 not-empty and bit 7 short. Every other bit reads 0. A write to bits 0, 3–31 changes nothing.
- R3: The service bit is 1 exactly when at least one complete packet is stored. A packet counts as complete only after the byte that carries rx_eop with rx_valid. rx_eop without rx_valid is ignored.
- R4: The not-empty bit is 1 whenever any byte is held. This includes the bytes of a packet that is still arriving.
- R5: cpu_rdata shows the oldest byte of the oldest complete packet and reads 0 when no packet is complete. A cpu_pop advances past that byte. A cpu_pop is ignored when no packet is complete, even if bytes of an unfinished packet are held.
- R6: The packet-done bit sets in the cycle after a kept packet's last byte and clears when 1 is written to bit 1. If the set and the clear happen in the same cycle, the set wins.
- R7: If a byte arrives while all DEPTH bytes are occupied, the unfinished packet is removed and the remaining bytes of that packet, through its end-of-packet, are discarded. Such a packet does not set packet-done. The overflow bit then sets and stays set until 1 is written to bit 2. Writing 0 leaves it unchanged.
- R8: The short bit is 1 when the packet at the head of the buffer is complete and holds fewer than MAX_PKT bytes.
- R9: The CPU receives the bytes of all kept packets in exactly the order they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Serial-engine byte strobe |
| rx_data | input | 8 | Serial-engine byte |
| rx_eop | input | 1 | Marks the current byte as the last of its packet |
| cpu_pop | input | 1 | CPU consumes the head byte |
| cpu_rdata | output | 8 | Head byte of the oldest complete packet |
| csr_wr | input | 1 | CPU write strobe for the status word |
| csr_wdata | input | 32 | CPU write data; 1 in bits 1 or 2 clears that flag |
| csr_rdata | output | 32 | Status word |

## Verification
Two events can fall in the same cycle: a kept packet ends, and the CPU writes 1 to clear packet-done. The bench provokes this by issuing the clear write on the same clock edge as the final byte of a packet, while packet-done is already set. The bench judges the outcome by reading the status word in the next cycle: packet-done must still be 1. A plain clear write in a later cycle must then bring it to 0. The bench also overlaps an overflow with a packet that already sits in the buffer. It then checks that the stored packet comes out byte for byte and that nothing of the dropped packet remains.

// File: rtl/iso_rx_pkg.sv
package iso_rx_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned CSR_W  = 32;

    // positions a CPU driver decodes
    localparam int unsigned BIT_SVC   = 0;
    localparam int unsigned BIT_DONE  = 1;
    localparam int unsigned BIT_OVF   = 2;
    localparam int unsigned BIT_NE    = 6;
    localparam int unsigned BIT_SHORT = 7;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              last;
    } rx_byte_t;

    typedef struct packed {
        logic shrt;
        logic ne;
        logic ovf;
        logic done;
        logic svc;
    } rx_stat_t;

    function automatic logic [CSR_W-1:0] pack_status(rx_stat_t s);
        logic [CSR_W-1:0] w;
        w            = '0;
        w[BIT_SVC]   = s.svc;
        w[BIT_DONE]  = s.done;
        w[BIT_OVF]   = s.ovf;
        w[BIT_NE]    = s.ne;
        w[BIT_SHORT] = s.shrt;
        return w;
    endfunction

endpackage

// File: rtl/iso_rx_store.sv
module iso_rx_store
    import iso_rx_pkg::*;
#(
    parameter int unsigned DEPTH = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  rx_byte_t          wr_byte,
    input  logic              commit,
    input  logic              rollback,
    input  logic              pop,
    output rx_byte_t          head,
    output logic              full,
    output logic              any_bytes
);
    localparam int unsigned AW = $clog2(DEPTH);

    rx_byte_t      mem [DEPTH];
    logic [AW:0]   wptr, cptr, rptr;

    assign full      = (wptr[AW] != rptr[AW]) && (wptr[AW-1:0] == rptr[AW-1:0]);
    assign any_bytes = (wptr != rptr);
    assign head      = mem[rptr[AW-1:0]];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wptr[AW-1:0]] <= wr_byte;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr <= '0;
            cptr <= '0;
            rptr <= '0;
        end else begin
            if (rollback) begin
                wptr <= cptr;
            end else if (wr_en) begin
                wptr <= wptr + 1'b1;
                if (commit) begin
                    cptr <= wptr + 1'b1;
                end
            end
            if (pop) begin
                rptr <= rptr + 1'b1;
            end
        end
    end

endmodule

// File: rtl/iso_rx_pktq.sv
module iso_rx_pktq #(
    parameter int unsigned DEPTH   = 64,
    parameter int unsigned MAX_PKT = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic accept,
    input  logic commit,
    input  logic rollback,
    input  logic pop_last,
    output logic has_pkt,
    output logic head_short
);
    localparam int unsigned AW = $clog2(DEPTH);
    localparam int unsigned CW = $clog2(DEPTH + 1);

    logic [CW-1:0]    cnt;
    logic [CW-1:0]    len;
    logic [DEPTH-1:0] shortq;
    logic [AW-1:0]    qhead, qtail;
    logic             is_short;

    assign is_short   = (int'(len) + 1) < int'(MAX_PKT);
    assign has_pkt    = (cnt != '0);
    assign head_short = has_pkt && shortq[qhead];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            len    <= '0;
            shortq <= '0;
            qhead  <= '0;
            qtail  <= '0;
        end else begin
            if (commit || rollback) begin
                len <= '0;
            end else if (accept) begin
                len <= len + 1'b1;
            end
            if (commit) begin
                shortq[qtail] <= is_short;
                qtail         <= qtail + 1'b1;
            end
            if (pop_last) begin
                qhead <= qhead + 1'b1;
            end
            case ({commit, pop_last})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

endmodule

// File: rtl/iso_rx_csr.sv
module iso_rx_csr
    import iso_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             set_done,
    input  logic             set_ovf,
    input  logic             csr_wr,
    input  logic [CSR_W-1:0] csr_wdata,
    input  logic             svc,
    input  logic             ne,
    input  logic             shrt,
    output logic [CSR_W-1:0] csr_rdata
);
    logic     done_q, ovf_q;
    logic     clr_done, clr_ovf;
    rx_stat_t stat;
    logic     unused_wbits;

    assign clr_done     = csr_wr && csr_wdata[BIT_DONE];
    assign clr_ovf      = csr_wr && csr_wdata[BIT_OVF];
    assign unused_wbits = ^{csr_wdata[CSR_W-1:BIT_OVF+1], csr_wdata[BIT_SVC]};

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b0;
            ovf_q  <= 1'b0;
        end else begin
            done_q <= set_done || (done_q && !clr_done);
            ovf_q  <= set_ovf  || (ovf_q  && !clr_ovf);
        end
    end

    always_comb begin
        stat.svc  = svc;
        stat.done = done_q;
        stat.ovf  = ovf_q;
        stat.ne   = ne;
        stat.shrt = shrt;
        csr_rdata = pack_status(stat);
    end

endmodule

// File: rtl/iso_out_rxbuf.sv
module iso_out_rxbuf
    import iso_rx_pkg::*;
#(
    parameter int unsigned DEPTH   = 64,
    parameter int unsigned MAX_PKT = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              rx_eop,
    input  logic              cpu_pop,
    output logic [BYTE_W-1:0] cpu_rdata,
    input  logic              csr_wr,
    input  logic [CSR_W-1:0]  csr_wdata,
    output logic [CSR_W-1:0]  csr_rdata
);
    logic     dropping;
    logic     full, any_bytes, has_pkt, head_short;
    logic     accept, commit, rollback, pop_ok, pop_last;
    rx_byte_t wr_byte, head;

    assign accept   = rx_valid && !dropping && !full;
    assign commit   = accept && rx_eop;
    assign rollback = rx_valid && !dropping && full;
    assign pop_ok   = cpu_pop && has_pkt;
    assign pop_last = pop_ok && head.last;

    assign wr_byte.data = rx_data;
    assign wr_byte.last = rx_eop;
    assign cpu_rdata    = has_pkt ? head.data : '0;

    // discard the tail of a packet that hit a full buffer
    always_ff @(posedge clk) begin
        if (rst) begin
            dropping <= 1'b0;
        end else if (dropping) begin
            dropping <= !(rx_valid && rx_eop);
        end else begin
            dropping <= rollback && !rx_eop;
        end
    end

    iso_rx_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (accept),
        .wr_byte   (wr_byte),
        .commit    (commit),
        .rollback  (rollback),
        .pop       (pop_ok),
        .head      (head),
        .full      (full),
        .any_bytes (any_bytes)
    );

    iso_rx_pktq #(.DEPTH(DEPTH), .MAX_PKT(MAX_PKT)) u_pktq (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .commit     (commit),
        .rollback   (rollback),
        .pop_last   (pop_last),
        .has_pkt    (has_pkt),
        .head_short (head_short)
    );

    iso_rx_csr u_csr (
        .clk       (clk),
        .rst       (rst),
        .set_done  (commit),
        .set_ovf   (rollback),
        .csr_wr    (csr_wr),
        .csr_wdata (csr_wdata),
        .svc       (has_pkt),
        .ne        (any_bytes),
        .shrt      (head_short),
        .csr_rdata (csr_rdata)
    );

endmodule

// File: rtl/iso_out_rxbuf_chk.sv
module iso_out_rxbuf_chk
    import iso_rx_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              rx_valid,
    input logic              rx_eop,
    input logic              cpu_pop,
    input logic [BYTE_W-1:0] cpu_rdata,
    input logic              csr_wr,
    input logic [CSR_W-1:0]  csr_wdata,
    input logic [CSR_W-1:0]  csr_rdata
);
    // R3 / R4: a complete packet implies stored bytes
    a_r3_service_needs_bytes: assert property (@(posedge clk) disable iff (rst)
        csr_rdata[BIT_SVC] |-> csr_rdata[BIT_NE]);

    // R6: packet-done only rises after a last byte
    a_r6_done_after_eop: assert property (@(posedge clk) disable iff (rst)
        $rose(csr_rdata[BIT_DONE]) |-> $past(rx_valid && rx_eop));

    // R7: overflow is sticky unless cleared by writing 1
    a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        (csr_rdata[BIT_OVF] && !(csr_wr && csr_wdata[BIT_OVF])) |=> csr_rdata[BIT_OVF]);

    // R7: overflow only rises when a byte was offered
    a_r7_ovf_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(csr_rdata[BIT_OVF]) |-> $past(rx_valid));

    // R5: head byte holds while nothing is popped
    a_r5_head_stable: assert property (@(posedge clk) disable iff (rst)
        (csr_rdata[BIT_SVC] && !cpu_pop) |=> (!csr_rdata[BIT_SVC] || $stable(cpu_rdata)));

    // R8: short bit only for a complete head packet
    a_r8_short_needs_pkt: assert property (@(posedge clk) disable iff (rst)
        csr_rdata[BIT_SHORT] |-> csr_rdata[BIT_SVC]);

endmodule

bind iso_out_rxbuf iso_out_rxbuf_chk u_chk (.*);

// File: tb/iso_out_rxbuf_tb.sv
module iso_out_rxbuf_tb;
    localparam int DEPTH   = 64;
    localparam int MAX_PKT = 16;

    logic        clk = 1'b0;
    logic        rst;
    logic        rx_valid, rx_eop, cpu_pop, csr_wr;
    logic [7:0]  rx_data, cpu_rdata;
    logic [31:0] csr_wdata, csr_rdata;

    int   nchk = 0, nerr = 0, used = 0;
    bit   done = 1'b0;
    byte unsigned exp_q[$];

    always #4 clk = ~clk;

    iso_out_rxbuf #(.DEPTH(DEPTH), .MAX_PKT(MAX_PKT)) u_dut (.*);

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic csr_write(logic [31:0] v);
        csr_wr = 1'b1; csr_wdata = v;
        tick();
        csr_wr = 1'b0; csr_wdata = '0;
    endtask

    // driver: offers a packet and records what the model expects to be kept
    task automatic send_pkt(int n, int base, bit clr_at_end);
        bit keep = (used + n <= DEPTH);
        for (int i = 0; i < n; i++) begin
            rx_valid = 1'b1;
            rx_data  = 8'(base + i);
            rx_eop   = (i == n - 1);
            if (clr_at_end && i == n - 1) begin
                csr_wr = 1'b1; csr_wdata = 32'h2;
            end
            tick();
            if (keep) exp_q.push_back(8'(base + i));
        end
        rx_valid = 1'b0; rx_eop = 1'b0; csr_wr = 1'b0; csr_wdata = '0;
        if (keep) used += n;
    endtask

    // monitor: pops bytes and compares against the scoreboard
    task automatic drain(int n, string req);
        for (int i = 0; i < n; i++) begin
            byte unsigned e = exp_q.pop_front();
            check(req, 32'(cpu_rdata), 32'(e));
            cpu_pop = 1'b1;
            tick();
            cpu_pop = 1'b0;
        end
        used -= n;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        rst = 1'b1; rx_valid = 0; rx_eop = 0; rx_data = 0;
        cpu_pop = 0; csr_wr = 0; csr_wdata = 0;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        check("R1 csr reset", csr_rdata, 32'h0);
        check("R1 rdata reset", 32'(cpu_rdata), 32'h0);

        // unfinished packet: bytes held, no service, pop ignored
        for (int i = 0; i < 5; i++) begin
            rx_valid = 1; rx_data = 8'(8'h10 + i); rx_eop = 0;
            tick();
        end
        rx_valid = 0;
        check("R4 not-empty mid-packet", csr_rdata, 32'h40);
        check("R3 no service mid-packet", 32'(csr_rdata[0]), 32'h0);
        check("R5 rdata zero mid-packet", 32'(cpu_rdata), 32'h0);
        cpu_pop = 1; tick(); cpu_pop = 0;
        rx_eop = 1; tick(); rx_eop = 0;          // eop without valid
        check("R3 lone eop ignored", csr_rdata, 32'h40);
        rx_valid = 1; rx_data = 8'h15; rx_eop = 1; tick();
        rx_valid = 0; rx_eop = 0;
        for (int i = 0; i < 6; i++) exp_q.push_back(8'(8'h10 + i));
        used = 6;
        check("R3 R6 R8 after 6-byte packet", csr_rdata, 32'hC3);
        csr_write(32'hFFFF_FFF9);
        check("R2 read-only writes ignored", csr_rdata, 32'hC3);
        csr_write(32'h2);
        check("R6 done cleared", csr_rdata, 32'hC1);
        drain(6, "R5 R9 first packet");
        check("R5 empty after drain", csr_rdata, 32'h0);

        // head full-size, then short
        send_pkt(16, 8'h20, 0);
        send_pkt(5, 8'h40, 0);
        check("R8 full-size head", csr_rdata, 32'h43);
        drain(16, "R9 full-size packet");
        check("R8 short head", csr_rdata, 32'hC3);
        drain(5, "R9 short packet");
        check("R4 empty keeps done", csr_rdata, 32'h02);
        csr_write(32'h2);

        // overflow on a completely full buffer
        for (int p = 0; p < 4; p++) send_pkt(16, 8'h50 + 16 * p, 0);
        send_pkt(5, 8'hA0, 0);
        check("R7 overflow set", csr_rdata, 32'h47);
        csr_write(32'h0);
        check("R7 write 0 keeps overflow", csr_rdata, 32'h47);
        csr_write(32'h4);
        check("R7 overflow cleared", csr_rdata, 32'h43);
        drain(64, "R7 R9 no trace of dropped packet");
        check("R7 empty after drain", csr_rdata, 32'h02);

        // partial packet rolled back behind a stored one
        send_pkt(40, 8'h00, 0);
        csr_write(32'h2);
        send_pkt(30, 8'h80, 0);
        check("R7 dropped packet sets no done", csr_rdata, 32'h45);
        send_pkt(3, 8'hC0, 0);
        check("R7 accepts after drop", csr_rdata, 32'h47);
        drain(40, "R7 R9 stored packet intact");
        check("R8 short head after rollback", csr_rdata, 32'hC7);
        drain(3, "R9 packet after drop");
        check("R4 empty after rollback", csr_rdata, 32'h06);

        // set and clear of done in the same cycle
        csr_write(32'h4);
        send_pkt(2, 8'hE0, 1);
        check("R6 set wins over clear", 32'(csr_rdata[1]), 32'h1);
        csr_write(32'h2);
        check("R6 later clear", 32'(csr_rdata[1]), 32'h0);
        drain(2, "R9 last packet");
        check("R1 idle at end", csr_rdata, 32'h0);

        finish_run();
    end

endmodule